// File: doc/BRIEF.md
# Register-Pair and Status Stack Unit

This unit carries out the stack side of a byte-oriented processor. It owns the 16-bit stack pointer and reaches stack memory through a byte-wide synchronous port that returns read data one cycle after the request. A single start pulse, with an operation code and a pair select, launches one multi-cycle operation. The unit samples the register values, the accumulator and the five condition flags in that start cycle.

The operations are:
- push and pop of one of three register pairs;
- push and pop of the status word, which is the accumulator plus a packed flag byte;
- an in-place swap of HL with the two bytes at the top of the stack;
- a direct load of the stack pointer from HL.

Popped pairs, swapped HL values, the restored accumulator and the restored flags appear on the result ports. Those ports hold their values until a later operation writes them. A one-cycle done pulse marks the first cycle in which the results and the new stack pointer are visible.

Top module: `stk_unit`

## Requirements
- R1: After reset `sp_o` equals the parameter `SP_RESET` (default 16'h0100). All result outputs, `done_o`, `busy_o` and `mem_en_o` are 0.
- R2: Operation code 0 pushes a pair. Pair select codes are 0 for B/C, 1 for D/E and 2 for H/L. The high register is written at SP-1, then the low register at SP-2, and SP then becomes SP-2.
- R3: Operation code 1 pops a pair. `pair_lo_o` takes the byte at SP, `pair_hi_o` takes the byte at SP+1, and SP becomes SP+2.
- R4: Pair push and pair pop leave `acc_o` and every flag output unchanged.
- R5: Operation code 2 pushes the status word. The accumulator goes to SP-1 and the flag byte goes to SP-2, and SP becomes SP-2. The flag byte is, from bit 7 down to bit 0: S, Z, 0, AC, 0, P, 1, C.
- R6: Operation code 3 pops the status word. The flag byte is read at SP and each flag is loaded from its bit position, with bits 5, 3 and 1 ignored. The accumulator is then read from SP+1, and SP becomes SP+2.
- R7: Operation code 4 exchanges HL with the top of the stack. L is stored at SP and H at SP+1. The old byte at SP appears on `pair_lo_o` and the old byte at SP+1 on `pair_hi_o`. SP is unchanged.
- R8: Operation code 5 loads SP with {H, L}. It makes no memory access, and `done_o` rises in the first cycle after the start cycle.
- R9: For pair push or pop, pair select code 3 is refused. The operation still completes with `done_o`, but makes no memory access and leaves SP and all results unchanged.
- R10: `done_o` is high for exactly one cycle per operation. SP changes only in a done cycle. `start_i` is ignored while `busy_o` is high. `mem_en_o` is 0 whenever `busy_o` is 0.
- R11: All stack address arithmetic and SP updates wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch an operation when idle |
| op_i | input | 3 | Operation code |
| pair_i | input | 2 | Pair select for pair push/pop |
| b_i | input | 8 | Register B |
| c_i | input | 8 | Register C |
| d_i | input | 8 | Register D |
| e_i | input | 8 | Register E |
| h_i | input | 8 | Register H |
| l_i | input | 8 | Register L |
| acc_i | input | 8 | Accumulator |
| s_i | input | 1 | Sign flag |
| z_i | input | 1 | Zero flag |
| ac_i | input | 1 | Auxiliary carry flag |
| p_i | input | 1 | Parity flag |
| cy_i | input | 1 | Carry flag |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 16 | Stack pointer |
| pair_hi_o | output | 8 | Popped or exchanged high byte |
| pair_lo_o | output | 8 | Popped or exchanged low byte |
| acc_o | output | 8 | Restored accumulator |
| s_o | output | 1 | Restored sign flag |
| z_o | output | 1 | Restored zero flag |
| ac_o | output | 1 | Restored auxiliary carry flag |
| p_o | output | 1 | Restored parity flag |
| cy_o | output | 1 | Restored carry flag |

## Verification
The exchange overlaps two functions in one cycle. Its third cycle captures the read data of the byte at SP+1 and, in the same cycle, writes the new L back to SP. The bench provokes this by exchanging against stack bytes placed by an earlier status pop. It judges the result from the returned H/L bytes and from the memory contents afterwards, which must show the swapped values with neither byte corrupted by the overlapping write. A second overlap is a start pulse arriving while a push is in flight; the bench checks that SP and memory reflect only the push.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_PUSH_RP  = 3'd0,
    OP_POP_RP   = 3'd1,
    OP_PUSH_PSW = 3'd2,
    OP_POP_PSW  = 3'd3,
    OP_XCHG_HL  = 3'd4,
    OP_LOAD_SP  = 3'd5,
    OP_RSVD6    = 3'd6,
    OP_RSVD7    = 3'd7
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_A1, ST_A2, ST_A3, ST_A4, ST_DONE
  } stk_state_e;

  localparam logic [1:0] RP_BC = 2'd0;
  localparam logic [1:0] RP_DE = 2'd1;
  localparam logic [1:0] RP_HL = 2'd2;
  localparam logic [1:0] RP_SP = 2'd3;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;
endpackage

// File: rtl/stk_psw_codec.sv
module stk_psw_codec
  import stk_pkg::*;
(
  input  flags_t            flg_i,
  output logic [BYTE_W-1:0] byte_o,
  input  logic [BYTE_W-1:0] byte_i,
  output flags_t            flg_o
);
  // fixed positions: 7 S, 6 Z, 5 '0', 4 AC, 3 '0', 2 P, 1 '1', 0 C
  assign byte_o = {flg_i.s, flg_i.z, 1'b0, flg_i.ac, 1'b0, flg_i.p, 1'b1, flg_i.cy};

  always_comb begin
    flg_o.s  = byte_i[7];
    flg_o.z  = byte_i[6];
    flg_o.ac = byte_i[4];
    flg_o.p  = byte_i[2];
    flg_o.cy = byte_i[0];
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  stk_op_e    op_i,
  input  logic       rp_ok_i,
  output stk_state_e state_o,
  output stk_op_e    op_o,
  output logic       accept_o,
  output logic       busy_o,
  output logic       done_o
);
  stk_state_e state_q, state_d;
  stk_op_e    op_q;
  logic       needs_mem;

  assign accept_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    unique case (op_i)
      OP_PUSH_RP, OP_POP_RP:               needs_mem = rp_ok_i;
      OP_PUSH_PSW, OP_POP_PSW, OP_XCHG_HL: needs_mem = 1'b1;
      default:                             needs_mem = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = needs_mem ? ST_A1 : ST_DONE;
      ST_A1:   state_d = ST_A2;
      ST_A2:   state_d = ST_A3;
      ST_A3:   state_d = (op_q == OP_XCHG_HL) ? ST_A4 : ST_DONE;
      ST_A4:   state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PUSH_RP;
    end else begin
      state_q <= state_d;
      if (accept_o) op_q <= op_i;
    end
  end

  assign state_o = state_q;
  assign op_o    = op_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] SP_RESET = AW'(16'h0100)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        pair_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic [BYTE_W-1:0] c_i,
  input  logic [BYTE_W-1:0] d_i,
  input  logic [BYTE_W-1:0] e_i,
  input  logic [BYTE_W-1:0] h_i,
  input  logic [BYTE_W-1:0] l_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic              s_i,
  input  logic              z_i,
  input  logic              ac_i,
  input  logic              p_i,
  input  logic              cy_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     sp_o,
  output logic [BYTE_W-1:0] pair_hi_o,
  output logic [BYTE_W-1:0] pair_lo_o,
  output logic [BYTE_W-1:0] acc_o,
  output logic              s_o,
  output logic              z_o,
  output logic              ac_o,
  output logic              p_o,
  output logic              cy_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  stk_state_e        state;
  stk_op_e           op_q;
  logic              accept, is_push, is_pop, finish;
  logic [AW-1:0]     sp_q;
  logic [BYTE_W-1:0] sel_hi, sel_lo, wr_hi_q, wr_lo_q, rd_lo_q, rd_hi_q, flag_byte;
  flags_t            flags_in, flags_pop, flags_q;

  stk_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (stk_op_e'(op_i)),
    .rp_ok_i  (pair_i != RP_SP),
    .state_o  (state),
    .op_o     (op_q),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  assign flags_in = '{s: s_i, z: z_i, ac: ac_i, p: p_i, cy: cy_i};

  stk_psw_codec u_psw (
    .flg_i  (flags_in),
    .byte_o (flag_byte),
    .byte_i (rd_lo_q),
    .flg_o  (flags_pop)
  );

  always_comb begin
    unique case (pair_i)
      RP_BC:   begin sel_hi = b_i; sel_lo = c_i; end
      RP_DE:   begin sel_hi = d_i; sel_lo = e_i; end
      default: begin sel_hi = h_i; sel_lo = l_i; end
    endcase
  end

  assign is_push = (op_q == OP_PUSH_RP) || (op_q == OP_PUSH_PSW);
  assign is_pop  = (op_q == OP_POP_RP)  || (op_q == OP_POP_PSW);
  assign finish  = ((state == ST_A3) && (op_q != OP_XCHG_HL)) || (state == ST_A4);

  // memory request per step
  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = sp_q;
    mem_wdata_o = wr_hi_q;
    unique case (state)
      ST_A1: begin
        mem_en_o   = 1'b1;
        mem_we_o   = is_push;
        mem_addr_o = is_push ? sp_q - ONE : sp_q;
      end
      ST_A2: begin
        mem_en_o    = 1'b1;
        mem_we_o    = is_push;
        mem_addr_o  = is_push ? sp_q - TWO : sp_q + ONE;
        mem_wdata_o = wr_lo_q;
      end
      ST_A3: if (op_q == OP_XCHG_HL) begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = wr_lo_q;
      end
      ST_A4: begin
        mem_en_o   = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = sp_q + ONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q      <= SP_RESET;
      wr_hi_q   <= '0;
      wr_lo_q   <= '0;
      rd_lo_q   <= '0;
      rd_hi_q   <= '0;
      pair_hi_o <= '0;
      pair_lo_o <= '0;
      acc_o     <= '0;
      flags_q   <= '0;
    end else begin
      if (accept) begin
        unique case (stk_op_e'(op_i))
          OP_PUSH_RP:  begin wr_hi_q <= sel_hi; wr_lo_q <= sel_lo;    end
          OP_PUSH_PSW: begin wr_hi_q <= acc_i;  wr_lo_q <= flag_byte; end
          default:     begin wr_hi_q <= h_i;    wr_lo_q <= l_i;       end
        endcase
        if (stk_op_e'(op_i) == OP_LOAD_SP) sp_q <= AW'({h_i, l_i});
      end
      if (state == ST_A2) rd_lo_q <= mem_rdata_i;
      if (state == ST_A3) rd_hi_q <= mem_rdata_i;
      if (finish) begin
        if (is_push) sp_q <= sp_q - TWO;
        if (is_pop)  sp_q <= sp_q + TWO;
        unique case (op_q)
          OP_POP_RP:  begin pair_hi_o <= mem_rdata_i; pair_lo_o <= rd_lo_q; end
          OP_POP_PSW: begin acc_o <= mem_rdata_i; flags_q <= flags_pop;     end
          OP_XCHG_HL: begin pair_hi_o <= rd_hi_q; pair_lo_o <= rd_lo_q;     end
          default: ;
        endcase
      end
    end
  end

  assign sp_o = sp_q;
  assign s_o  = flags_q.s;
  assign z_o  = flags_q.z;
  assign ac_o = flags_q.ac;
  assign p_o  = flags_q.p;
  assign cy_o = flags_q.cy;
endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk
  import stk_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [2:0]    op_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] sp_o,
  input logic          mem_en_o,
  input logic          mem_we_o
);
  logic          live_q;
  logic [2:0]    op_lat_q;
  logic [AW-1:0] sp_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q   <= 1'b0;
      op_lat_q <= '0;
      sp_lat_q <= '0;
    end else begin
      live_q <= 1'b1;
      if (start_i && !busy_o) begin
        op_lat_q <= op_i;
        sp_lat_q <= sp_o;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_MEM_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_en_o); // R10
  AST_WE_WITH_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o); // R10
  AST_SP_MOVES_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$stable(sp_o)) |-> done_o); // R10
  AST_XCHG_SP_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_lat_q == OP_XCHG_HL) |-> (sp_o == sp_lat_q)); // R7
  AST_LOADSP_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_lat_q == OP_LOAD_SP) |-> !mem_en_o); // R8
endmodule

bind stk_unit stk_unit_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .sp_o     (sp_o),
  .mem_en_o (mem_en_o),
  .mem_we_o (mem_we_o)
);

// File: tb/stk_unit_bench.sv
module stk_unit_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [1:0] pair_i = '0;
  logic [7:0] b_i = '0, c_i = '0, d_i = '0, e_i = '0, h_i = '0, l_i = '0, acc_i = '0;
  logic s_i = 0, z_i = 0, ac_i = 0, p_i = 0, cy_i = 0;
  logic mem_en_o, mem_we_o, busy_o, done_o;
  logic [15:0] mem_addr_o, sp_o;
  logic [7:0] mem_wdata_o, mem_rdata_i, pair_hi_o, pair_lo_o, acc_o;
  logic s_o, z_o, ac_o, p_o, cy_o;

  int tests = 0, fails = 0, cycles = 0;
  logic [7:0]  mem [256];
  logic [15:0] wa_prev, wa_last;
  int wr_cnt = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stk_unit u_stk_unit (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (mem_en_o) begin
      if (mem_we_o) begin
        mem[mem_addr_o[7:0]] <= mem_wdata_o;
        wa_prev <= wa_last;
        wa_last <= mem_addr_o;
        wr_cnt  <= wr_cnt + 1;
      end
      mem_rdata_i <= mem[mem_addr_o[7:0]];
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [1:0] pr, output int n);
    @(negedge clk_i);
    op_i = op; pair_i = pr; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 1;
    while (!done_o && n < 20) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  function automatic logic [4:0] flg();
    return {s_o, z_o, ac_o, p_o, cy_o};
  endfunction

  task automatic t_reset();
    chk("R1 sp", sp_o, 16'h0100);
    chk("R1 ctl", {done_o, busy_o, mem_en_o}, 0);
    chk("R1 res", {pair_hi_o, pair_lo_o}, 0);
    chk("R1 psw", {acc_o, 3'b0, flg()}, 0);
  endtask

  task automatic t_psw_push();
    int n;
    acc_i = 8'hA5; {s_i, z_i, ac_i, p_i, cy_i} = 5'b10101;
    run_op(3'd2, 2'd0, n);
    chk("R5 acc at SP-1", mem[8'hFF], 8'hA5);
    chk("R5 flag byte at SP-2", mem[8'hFE], 8'h93);
    chk("R5 sp", sp_o, 16'h00FE);
  endtask

  task automatic t_psw_pop();
    int n;
    run_op(3'd3, 2'd0, n);
    chk("R6 acc", acc_o, 8'hA5);
    chk("R6 flags", flg(), 5'b10101);
    chk("R6 sp", sp_o, 16'h0100);
    mem[8'h00] = 8'h68; mem[8'h01] = 8'h3C; // constant bits inverted
    run_op(3'd3, 2'd0, n);
    chk("R6 ignore const bits", flg(), 5'b01000);
    chk("R6 acc2", acc_o, 8'h3C);
    chk("R6 sp2", sp_o, 16'h0102);
  endtask

  task automatic t_load_sp();
    int n;
    h_i = 8'h01; l_i = 8'h00;
    run_op(3'd5, 2'd0, n);
    chk("R8 sp", sp_o, 16'h0100);
    chk("R8 latency", n, 1);
  endtask

  task automatic t_pair_push_pop();
    int n;
    b_i = 8'h12; c_i = 8'h34;
    run_op(3'd0, 2'd0, n);
    chk("R2 hi at SP-1", mem[8'hFF], 8'h12);
    chk("R2 lo at SP-2", mem[8'hFE], 8'h34);
    chk("R2 addr order", {wa_prev, wa_last}, {16'h00FF, 16'h00FE});
    chk("R2 sp", sp_o, 16'h00FE);
    chk("R4 psw kept push", {acc_o, 3'b0, flg()}, {8'h3C, 8'b0000_1000});
    run_op(3'd1, 2'd2, n);
    chk("R3 pair", {pair_hi_o, pair_lo_o}, 16'h1234);
    chk("R3 sp", sp_o, 16'h0100);
    chk("R4 psw kept pop", {acc_o, 3'b0, flg()}, {8'h3C, 8'b0000_1000});
  endtask

  task automatic t_xchg();
    int n;
    h_i = 8'h9A; l_i = 8'hBC;
    run_op(3'd4, 2'd0, n);
    chk("R7 old top", {pair_hi_o, pair_lo_o}, 16'h3C68);
    chk("R7 L at SP", mem[8'h00], 8'hBC);
    chk("R7 H at SP+1", mem[8'h01], 8'h9A);
    chk("R7 sp", sp_o, 16'h0100);
  endtask

  task automatic t_bad_pair();
    int n, w0;
    w0 = wr_cnt;
    run_op(3'd0, 2'd3, n);
    chk("R9 done", n < 20, 1);
    chk("R9 no write", wr_cnt, w0);
    chk("R9 sp", sp_o, 16'h0100);
    run_op(3'd1, 2'd3, n);
    chk("R9 pop refused", {pair_hi_o, pair_lo_o, sp_o}, {16'h3C68, 16'h0100});
  endtask

  task automatic t_busy_ignore();
    int n;
    d_i = 8'h56; e_i = 8'h78; h_i = 8'h12; l_i = 8'h34;
    @(negedge clk_i);
    op_i = 3'd0; pair_i = 2'd1; start_i = 1'b1;
    @(negedge clk_i);
    op_i = 3'd5;            // start held while busy
    @(negedge clk_i);
    start_i = 1'b0;
    n = 2;
    while (!done_o && n < 20) begin @(negedge clk_i); n++; end
    chk("R10 sp ignores busy start", sp_o, 16'h00FE);
    chk("R10 push data", {mem[8'hFF], mem[8'hFE]}, 16'h5678);
    @(negedge clk_i);
    chk("R10 done one cycle", done_o, 0);
  endtask

  task automatic t_wrap();
    int n;
    h_i = 8'h00; l_i = 8'h01;
    run_op(3'd5, 2'd0, n);
    d_i = 8'hC3; e_i = 8'hD4;
    run_op(3'd0, 2'd1, n);
    chk("R11 wrap addrs", {wa_prev, wa_last}, {16'h0000, 16'hFFFF});
    chk("R11 wrap sp", sp_o, 16'hFFFF);
    run_op(3'd1, 2'd0, n);
    chk("R11 wrap pop", {pair_hi_o, pair_lo_o}, 16'hC3D4);
    chk("R11 sp back", sp_o, 16'h0001);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_psw_push();
    t_psw_pop();
    t_load_sp();
    t_pair_push_pop();
    // SP=0100: top bytes are 68 (SP) and 3C (SP+1)
    t_xchg();
    t_bad_pair();
    t_busy_ignore();
    t_wrap();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule